// File: doc/BRIEF.md
# Programmable Edge and Level Interrupt Bank

This block watches a group of input pins (eight by default) and raises a request per pin when that pin shows the trigger condition programmed for it. Each channel can be set to rising edge, falling edge, any edge, high level or low level. All pins are brought into the sampling clock domain through a two-stage synchronizer. An edge is found by comparing the current synchronized sample with the one before it. Software sees a small bank of 32-bit registers and one combined interrupt line, which is high whenever any enabled channel has a pending request.

The trigger type of a channel comes from three configuration bits. The any-edge bit takes priority. When it is clear, the mode bit chooses between edge and level, and the polarity bit chooses the direction or the active level. Each channel keeps its pending status in a two-state machine:

- State `CH_IDLE`: nothing is pending.
- State `CH_PEND`: a request is pending.
- Transition `T_DETECT` goes from `CH_IDLE` to `CH_PEND` when the channel's trigger condition is present in a cycle.
- Transition `T_ACK` goes from `CH_PEND` to `CH_IDLE` when software writes a 1 to that channel's clear bit and no new trigger is present in the same cycle.
- In every other case the state holds, which is the `T_HOLD` self-loop.

A level channel keeps taking `T_DETECT` for as long as its level is active, so a clear only works once the pin has gone inactive. The bank is used in a chip wherever several slow external signals must each be turned into a maskable interrupt. Each cycle, a single write strobe with an address and data either programs the bank or clears requests. Reads are combinational from the address.

Top module: `irqb_top`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0. The pins are expected to be low while reset is applied.
- R2: Registers are decoded from byte address bits 4:2, and only when bits 1:0 are 0. The map is: 0x00 enable (rw), 0x04 pending (ro), 0x08 enabled-pending (ro), 0x0C clear (write-1, reads 0), 0x10 mode (rw, 1 = level), 0x14 any-edge (rw), 0x18 polarity (rw, 1 = rising/high), 0x1C pin level (ro). Channel n sits in bit n, and the bits above the channel count read 0. A misaligned address reads 0 and its writes are dropped.
- R3: A channel with any-edge=0, mode=0 and polarity=1 becomes pending on a 0-to-1 pin change. This shows in the pending register after the third rising clock edge that follows the pin change.
- R4: A channel with any-edge=0, mode=0 and polarity=0 becomes pending on a 1-to-0 pin change only.
- R5: With any-edge=1, a channel becomes pending on both pin transitions, whatever its mode and polarity bits hold. A steady level never re-triggers it.
- R6: With any-edge=0 and mode=1, a channel is pending whenever its synchronized pin equals the polarity bit. A clear then has no effect until the level goes inactive.
- R7: An edge-triggered pending bit stays set until a 1 is written to its clear bit. Writing 0 to a clear bit leaves it unchanged. A clear takes effect at the clock edge that samples the write.
- R8: When a clear and a new trigger for the same channel fall in the same cycle, the channel stays pending.
- R9: The enabled-pending register equals pending AND enable, and `irq` is the OR of its bits. A channel becomes pending whether or not it is enabled.
- R10: The pin-level register shows each pin's value after the second rising clock edge that follows the pin change.
- R11: Writes to the pending, enabled-pending and pin-level offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NCH | Raw external pins, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq | output | 1 | OR of all enabled pending channels |

## Verification
Each result has a fixed due time, counted from the rising edge that samples the stimulus:

- A configuration write and a clear show after the edge that samples them.
- A pin change reaches the pin-level register after the second edge.
- A pin change reaches the pending register after the third edge.
- `irq` and the enabled-pending register follow pending and enable in the same cycle.

The bench changes inputs only at falling edges, and it reads every register just after the following falling edge. Its reference model steps once per rising edge with the same register depth. The directed cases read the pending bits one cycle before and one cycle at the computed due edge, including the cycle where a clear meets a new edge.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

    // Byte address width of the register bank (eight 32-bit words)
    localparam int REG_AW = 5;

    // Word select, decoded from address bits 4:2
    typedef enum logic [2:0] {
        SEL_ENABLE = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_MASKED = 3'd2,
        SEL_CLEAR  = 3'd3,
        SEL_MODE   = 3'd4,
        SEL_ANYEDG = 3'd5,
        SEL_POL    = 3'd6,
        SEL_LEVEL  = 3'd7
    } reg_sel_e;

    localparam logic [REG_AW-1:0] OFS_CLEAR = 5'h0C;

    // Per-channel request state
    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } ch_state_e;

endpackage

// File: rtl/irqb_sync.sv
module irqb_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/irqb_chan.sv
module irqb_chan
    import irqb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp,        // synchronized pin sample
    input  logic cfg_mode,   // 1 = level
    input  logic cfg_both,   // 1 = any edge, overrides mode and polarity
    input  logic cfg_pol,    // 1 = rising / high
    input  logic clr,        // write-1 clear for this channel
    output logic evt,        // trigger present this cycle
    output logic raw         // pending
);

    logic      prev_q;
    logic      rise, fall;
    ch_state_e st_q, st_nx;

    // previous sample for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp;
    end

    // trigger decode: any-edge first, then mode, then polarity
    always_comb begin
        rise = smp & ~prev_q;
        fall = ~smp & prev_q;
        if (cfg_both)      evt = rise | fall;
        else if (cfg_mode) evt = cfg_pol ? smp : ~smp;
        else               evt = cfg_pol ? rise : fall;
    end

    // next state: T_DETECT, T_ACK, T_HOLD
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            CH_IDLE: if (evt) st_nx = CH_PEND;
            CH_PEND: if (clr && !evt) st_nx = CH_IDLE;
            default: st_nx = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_nx;
    end

    // outputs
    always_comb begin
        raw = (st_q == CH_PEND);
    end

endmodule

// File: rtl/irqb_regs.sv
module irqb_regs
    import irqb_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NCH-1:0]    raw,
    input  logic [NCH-1:0]    level,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    en,
    output logic [NCH-1:0]    mode,
    output logic [NCH-1:0]    both,
    output logic [NCH-1:0]    pol,
    output logic [NCH-1:0]    clr
);

    localparam int PAD_W = DATA_W - NCH;

    reg_sel_e       sel;
    logic           aligned;
    logic           wr_ok;
    logic [NCH-1:0] wbits;
    logic [NCH-1:0] rd_bits;
    logic           unused_wdata;

    assign sel          = reg_sel_e'(addr[REG_AW-1:2]);
    assign aligned      = (addr[1:0] == 2'b00);
    assign wr_ok        = wr && aligned;
    assign wbits        = wdata[NCH-1:0];
    assign unused_wdata = ^wdata[DATA_W-1:NCH];

    // write-1 clear strobes, valid only in the write cycle
    assign clr = (wr_ok && sel == SEL_CLEAR) ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en   <= '0;
            mode <= '0;
            both <= '0;
            pol  <= '0;
        end else if (wr_ok) begin
            unique case (sel)
                SEL_ENABLE: en   <= wbits;
                SEL_MODE:   mode <= wbits;
                SEL_ANYEDG: both <= wbits;
                SEL_POL:    pol  <= wbits;
                default:    ;
            endcase
        end
    end

    always_comb begin
        rd_bits = '0;
        if (aligned) begin
            unique case (sel)
                SEL_ENABLE: rd_bits = en;
                SEL_PEND:   rd_bits = raw;
                SEL_MASKED: rd_bits = raw & en;
                SEL_CLEAR:  rd_bits = '0;
                SEL_MODE:   rd_bits = mode;
                SEL_ANYEDG: rd_bits = both;
                SEL_POL:    rd_bits = pol;
                SEL_LEVEL:  rd_bits = level;
                default:    rd_bits = '0;
            endcase
        end
        rdata = {{PAD_W{1'b0}}, rd_bits};
    end

endmodule

// File: rtl/irqb_top.sv
module irqb_top #(
    parameter int NCH         = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             pin_in,
    input  logic                       reg_wr,
    input  logic [irqb_pkg::REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    output logic                       irq
);

    logic [NCH-1:0] smp_q;
    logic [NCH-1:0] raw_q;
    logic [NCH-1:0] evt_c;
    logic [NCH-1:0] cfg_en, cfg_mode, cfg_both, cfg_pol;
    logic [NCH-1:0] clr_c;

    irqb_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (smp_q)
    );

    irqb_regs #(.NCH(NCH), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .raw   (raw_q),
        .level (smp_q),
        .rdata (reg_rdata),
        .en    (cfg_en),
        .mode  (cfg_mode),
        .both  (cfg_both),
        .pol   (cfg_pol),
        .clr   (clr_c)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        irqb_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp      (smp_q[g]),
            .cfg_mode (cfg_mode[g]),
            .cfg_both (cfg_both[g]),
            .cfg_pol  (cfg_pol[g]),
            .clr      (clr_c[g]),
            .evt      (evt_c[g]),
            .raw      (raw_q[g])
        );
    end

    assign irq = |(raw_q & cfg_en);

endmodule

// File: rtl/irqb_chk.sv
module irqb_chk
    import irqb_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic [NCH-1:0]    raw,
    input logic [NCH-1:0]    evt,
    input logic [NCH-1:0]    smp,
    input logic [NCH-1:0]    en,
    input logic [NCH-1:0]    mode,
    input logic [NCH-1:0]    both
);

    logic [NCH-1:0] clrm;
    logic [NCH-1:0] edge_ch;
    logic           unused_hi;

    assign clrm      = (reg_wr && reg_addr == OFS_CLEAR) ? reg_wdata[NCH-1:0] : '0;
    assign edge_ch   = ~(mode & ~both);
    assign unused_hi = ^reg_wdata[DATA_W-1:NCH];

    // R7: a pending bit only drops where a clear was written
    p_drop_needs_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(raw) & ~raw & ~$past(clrm)) == '0));

    // R8: a trigger always leaves its channel pending, clear or not
    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & $past(evt)) == $past(evt)));

    // R3: an edge-type channel only triggers when its sample changed
    p_edge_needs_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & edge_ch & ~(smp ^ $past(smp))) == '0));

    // R9: nothing enabled means no interrupt
    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);

    // R2: the clear word always reads back as zero
    p_clear_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_CLEAR) |-> (reg_rdata == '0));

endmodule

bind irqb_top irqb_chk #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .raw       (raw_q),
    .evt       (evt_c),
    .smp       (smp_q),
    .en        (cfg_en),
    .mode      (cfg_mode),
    .both      (cfg_both)
);

// File: tb/irqb_top_test.sv
`timescale 1ns/1ps
module irqb_top_test;

    localparam logic [4:0] A_EN = 5'h00, A_PEND = 5'h04, A_MSK = 5'h08, A_CLR = 5'h0C,
                           A_MODE = 5'h10, A_BOTH = 5'h14, A_POL = 5'h18, A_LVL = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = 8'h00;
    logic        wr = 1'b0;
    logic [4:0]  addr = 5'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_en, m_mode, m_both, m_pol, m_raw, m_s1, m_s2, m_prev;

    always #10 clk = ~clk;

    irqb_top uut (
        .clk (clk), .rst_n (rst_n), .pin_in (pins), .reg_wr (wr),
        .reg_addr (addr), .reg_wdata (wdata), .reg_rdata (rdata), .irq (irq)
    );

    function automatic logic [7:0] model_evt();
        logic [7:0] rise, fall, lvl, edg;
        rise = m_s2 & ~m_prev;
        fall = ~m_s2 & m_prev;
        lvl  = (m_pol & m_s2) | (~m_pol & ~m_s2);
        edg  = (m_pol & rise) | (~m_pol & fall);
        return (m_both & (rise | fall)) | (~m_both & m_mode & lvl) | (~m_both & ~m_mode & edg);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_mode = 0; m_both = 0; m_pol = 0;
            m_raw = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            logic [7:0] ev, cm;
            ev = model_evt();
            cm = (wr && addr == A_CLR) ? wdata[7:0] : 8'h00;
            m_raw  = ev | (m_raw & ~cm);
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pins;
            if (wr && addr[1:0] == 2'b00) begin
                case (addr)
                    A_EN:   m_en   = wdata[7:0];
                    A_MODE: m_mode = wdata[7:0];
                    A_BOTH: m_both = wdata[7:0];
                    A_POL:  m_pol  = wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a)
            A_EN:   return {24'h0, m_en};
            A_PEND: return {24'h0, m_raw};
            A_MSK:  return {24'h0, m_raw & m_en};
            A_MODE: return {24'h0, m_mode};
            A_BOTH: return {24'h0, m_both};
            A_POL:  return {24'h0, m_pol};
            A_LVL:  return {24'h0, m_s2};
            default: return 32'h0;
        endcase
    endfunction

    task automatic expect_eq(input string tag, input string what,
                             input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(input logic [4:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        wr = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rd(5'(i * 4), v);
            expect_eq(tag, $sformatf("reg@%0h", i * 4), v, exp_read(5'(i * 4)));
        end
        expect_eq(tag, "irq", {31'h0, irq}, {31'h0, |(m_raw & m_en)});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all R1 to R11): actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int seed_sink;
        seed_sink = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_all("R1");
        expect_eq("R1", "irq after reset", {31'h0, irq}, 32'h0);

        // R2 / R11 register map, read-only and misaligned writes
        put(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, v);   expect_eq("R2", "enable upper bits", v, 32'h0000_00FF);
        put(A_PEND, 32'hFF); put(A_MSK, 32'hFF); put(A_LVL, 32'hFF);
        rd(A_PEND, v); expect_eq("R11", "pending after ro write", v, 32'h0);
        rd(A_LVL, v);  expect_eq("R11", "level after ro write", v, 32'h0);
        put(5'h11, 32'hFF);
        rd(A_MODE, v); expect_eq("R2", "misaligned write dropped", v, 32'h0);
        rd(5'h11, v);  expect_eq("R2", "misaligned read", v, 32'h0);
        check_all("R2");

        // R3 / R10 rising edge on channel 0 with exact timing
        put(A_POL, 32'h01);
        pins = 8'h01;
        tick();
        rd(A_LVL, v);  expect_eq("R10", "level after 1 edge", v, 32'h0);
        tick();
        rd(A_LVL, v);  expect_eq("R10", "level after 2 edges", v, 32'h01);
        rd(A_PEND, v); expect_eq("R3", "pending after 2 edges", v, 32'h0);
        tick();
        rd(A_PEND, v); expect_eq("R3", "pending after 3 edges", v, 32'h01);
        expect_eq("R9", "irq with pending", {31'h0, irq}, 32'h1);
        // R7 stickiness and write-0 clear
        pins = 8'h00;
        repeat (3) tick();
        rd(A_PEND, v); expect_eq("R7", "sticky after pin drop", v, 32'h01);
        put(A_CLR, 32'h00);
        rd(A_PEND, v); expect_eq("R7", "clear with 0", v, 32'h01);
        put(A_CLR, 32'h01);
        rd(A_PEND, v); expect_eq("R7", "clear with 1", v, 32'h0);
        check_all("R3");

        // R4 falling edge on channel 1
        pins = 8'h02;
        repeat (3) tick();
        rd(A_PEND, v); expect_eq("R4", "rise on falling channel", v, 32'h0);
        pins = 8'h00;
        repeat (3) tick();
        rd(A_PEND, v); expect_eq("R4", "fall on falling channel", v, 32'h02);
        put(A_CLR, 32'h02);

        // R5 any-edge overrides level-high configuration on channel 2
        put(A_POL, 32'h04); put(A_MODE, 32'h04); put(A_BOTH, 32'h04);
        pins = 8'h04;
        repeat (3) tick();
        rd(A_PEND, v); expect_eq("R5", "any-edge rise", v, 32'h04);
        put(A_CLR, 32'h04);
        repeat (2) tick();
        rd(A_PEND, v); expect_eq("R5", "steady high no retrigger", v, 32'h0);
        pins = 8'h00;
        repeat (3) tick();
        rd(A_PEND, v); expect_eq("R5", "any-edge fall", v, 32'h04);
        put(A_CLR, 32'h04);
        check_all("R5");

        // R6 levels: channel 3 high, channel 4 low
        put(A_MODE, 32'h00); put(A_BOTH, 32'h00); put(A_POL, 32'h08);
        put(A_MODE, 32'h18);
        rd(A_PEND, v); expect_eq("R6", "level low not yet seen", v, 32'h0);
        tick();
        rd(A_PEND, v); expect_eq("R6", "level low active", v, 32'h10);
        put(A_CLR, 32'h10);
        rd(A_PEND, v); expect_eq("R6", "clear while level active", v, 32'h10);
        pins = 8'h10;
        repeat (3) tick();
        put(A_CLR, 32'h10);
        rd(A_PEND, v); expect_eq("R6", "clear after level gone", v, 32'h0);
        pins = 8'h18;
        repeat (3) tick();
        rd(A_PEND, v); expect_eq("R6", "level high active", v, 32'h08);
        pins = 8'h10;
        repeat (3) tick();
        rd(A_PEND, v); expect_eq("R6", "level pending held", v, 32'h08);
        put(A_CLR, 32'h08);
        check_all("R6");

        // R8 clear meets a falling edge on channel 5 in the same cycle
        pins = 8'h30;
        repeat (3) tick();
        pins = 8'h10;
        tick();
        tick();
        put(A_CLR, 32'h20);
        rd(A_PEND, v); expect_eq("R8", "event beats clear", v, 32'h20);

        // R9 masking
        put(A_EN, 32'h00);
        expect_eq("R9", "irq disabled", {31'h0, irq}, 32'h0);
        rd(A_MSK, v);  expect_eq("R9", "masked disabled", v, 32'h0);
        rd(A_PEND, v); expect_eq("R9", "pending kept when disabled", v, 32'h20);
        put(A_EN, 32'h20);
        expect_eq("R9", "irq enabled", {31'h0, irq}, 32'h1);
        rd(A_MSK, v);  expect_eq("R9", "masked enabled", v, 32'h20);
        put(A_EN, 32'hFF);
        put(A_CLR, 32'hFF);
        check_all("R9");

        // random phase against the model
        for (int n = 0; n < 3000; n++) begin
            int r;
            pins = pins ^ 8'($urandom & $urandom & $urandom);
            r = int'($urandom % 20);
            if (r < 2) begin
                logic [4:0] cfg_a [4];
                cfg_a = '{A_EN, A_MODE, A_BOTH, A_POL};
                wr = 1'b1; addr = cfg_a[$urandom % 4]; wdata = $urandom;
            end else if (r < 5) begin
                wr = 1'b1; addr = A_CLR; wdata = $urandom;
            end else if (r == 5) begin
                wr = 1'b1; addr = 5'($urandom % 32); wdata = $urandom;
            end else begin
                wr = 1'b0;
            end
            tick();
            wr = 1'b0;
            check_all("random R2/R4/R5/R6/R7/R8/R9/R10");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule